// File: doc/BRIEF.md
# Stepper Motor Acceleration Ramp Controller

This block paces the step pulses sent to a stepping-motor driver. The spacing between pulses is set by a 4-bit delay value. While the motor accelerates, the delay drops by one at every step. While it decelerates, the delay rises by one at every step. Each time a pulse goes out, an up-counting interval timer is reloaded from the delay value. When the timer reaches its terminal count, the controller issues the next pulse. The speed therefore ramps step by step between a slowest and a fastest rate.

Three command inputs choose the ramp direction: run (accelerate), freeze and stop (decelerate). Each one passes through a two-stage synchronizer and an edge detector, so only a rising edge acts. A rising edge becomes a one-cycle request inside the block. A run command also starts a motor that is idle. A stop command lets the motor slow to the slowest rate, issue one last pulse, and fall back to idle. Two status outputs report when the delay sits at either limit.

Top module: `step_ramp_ctrl`

## Requirements
- R1: While reset is applied and after it is released, the block is idle: step_o is 0, the delay is 15, max_dly_o is 1 and min_dly_o is 0.
- R2: A command acts only on a rising edge of its input, after synchronization. A run edge applied to an idle motor whose delay is 15 gives the first step pulse 19 clock edges after the input rises. Holding an input high does not retrigger it.
- R3: step_o is high for exactly one cycle. The time from one pulse to the next is D+2 clock cycles, where D is the delay after the update made at the earlier pulse. The delay changes only when a pulse is issued or a load-to-zero occurs.
- R4: In accelerate mode, each pulse lowers the delay by one until it reaches 0. Starting from reset, the intervals are therefore 16, 15, and so on down to 2.
- R5: Once the delay is 0 in accelerate mode, it stays at 0 and pulses keep coming every 2 cycles.
- R6: In decelerate mode, each pulse raises the delay by one until it reaches 15. The pulse issued while the delay is already 15 is the last one, and the block then goes idle. The intervals before that last pulse grow from 3 to 17.
- R7: In freeze mode, the delay keeps its value and pulses continue at a constant interval. A later run edge resumes acceleration.
- R8: A stop or freeze edge does not start an idle motor.
- R9: When run and freeze edges are seen in the same cycle, the delay is loaded to 0 and the mode becomes freeze. An idle motor starts, and it then steps every 2 cycles.
- R10: When stop and run edges are seen in the same cycle, stop takes priority. An idle motor stays idle.
- R11: min_dly_o is 1 exactly when the delay is 0, and max_dly_o is 1 exactly when the delay is 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| go_i | input | 1 | Run / accelerate command (asynchronous, edge-acting) |
| hold_i | input | 1 | Freeze-delay command (asynchronous, edge-acting) |
| halt_i | input | 1 | Stop / decelerate command (asynchronous, edge-acting) |
| step_o | output | 1 | One-cycle step pulse to the motor driver |
| min_dly_o | output | 1 | Delay is at its minimum (fastest rate) |
| max_dly_o | output | 1 | Delay is at its maximum (slowest rate) |

## Verification
The assertions assume that command inputs are level signals that stay stable for at least two clock cycles. Under that assumption each edge produces exactly one internal request. The stimulus only changes inputs on the falling clock edge and holds each level for many cycles. Requests that must coincide are raised on the same falling edge, so they pass through the synchronizers together. Inputs are held low while reset is applied, so no request is made when reset is released.

// File: rtl/step_ramp_pkg.sv
package step_ramp_pkg;
  typedef enum logic [1:0] {
    M_ACCEL = 2'd0,
    M_HOLD  = 2'd1,
    M_DECEL = 2'd2
  } ramp_mode_e;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_RUN  = 1'b1
  } run_state_e;

  localparam int unsigned CMD_GO   = 0;
  localparam int unsigned CMD_HOLD = 1;
  localparam int unsigned CMD_HALT = 2;
  localparam int unsigned CMD_N    = 3;
endpackage

// File: rtl/cmd_sync.sv
module cmd_sync #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cmd_i,
  output logic [N-1:0] req_o
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= cmd_i[i];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end

    assign req_o[i] = sync_q & ~prev_q;

    // A request lasts a single cycle (R2: edge-acting commands).
    p_req_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_o[i] |=> !req_o[i]);
  end
endmodule

// File: rtl/delay_reg.sv
module delay_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         dec_i,
  input  logic         zero_i,
  output logic [W-1:0] dly_o,
  output logic         min_o,
  output logic         max_o
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] DMAX = {W{1'b1}};

  logic [W-1:0] dly_q, dly_d;

  always_comb begin
    dly_d = dly_q;
    if (zero_i)     dly_d = '0;
    else if (dec_i) dly_d = dly_q - ONE;
    else if (inc_i) dly_d = dly_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dly_q <= DMAX;
    else        dly_q <= dly_d;
  end

  assign dly_o = dly_q;
  assign min_o = (dly_q == '0);
  assign max_o = (dly_q == DMAX);

  // The controller must never request a step past either limit.
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_i |-> (dly_q != '0));
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inc_i |-> (dly_q != DMAX));
endmodule

// File: rtl/interval_cnt.sv
module interval_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         en_i,
  output logic         tc_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)    cnt_d = load_val_i;
    else if (en_i) cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tc_o = &cnt_q;

  // The count never wraps: the enable must be withheld at terminal count (R3).
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> !tc_o);
endmodule

// File: rtl/step_ramp_ctrl.sv
module step_ramp_ctrl #(
  parameter int unsigned DLY_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  input  logic hold_i,
  input  logic halt_i,
  output logic step_o,
  output logic min_dly_o,
  output logic max_dly_o
);
  import step_ramp_pkg::*;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  logic [CMD_N-1:0] req;
  logic go_r, hold_r, halt_r;

  cmd_sync #(.N(CMD_N)) u_sync (
    .clk   (clk),
    .rst_n (rst_s),
    .cmd_i ({halt_i, hold_i, go_i}),
    .req_o (req)
  );

  assign go_r   = req[CMD_GO];
  assign hold_r = req[CMD_HOLD];
  assign halt_r = req[CMD_HALT];

  run_state_e st_q, st_d;
  ramp_mode_e mode_q, mode_d;
  logic       step_q, step_d;
  logic       start, ld_zero, fire, last_step, dly_inc, dly_dec;
  logic       tc, at_min, at_max, cnt_load, cnt_en;
  logic [DLY_W-1:0] dly;

  delay_reg #(.W(DLY_W)) u_dly (
    .clk    (clk),
    .rst_n  (rst_s),
    .inc_i  (dly_inc),
    .dec_i  (dly_dec),
    .zero_i (ld_zero),
    .dly_o  (dly),
    .min_o  (at_min),
    .max_o  (at_max)
  );

  interval_cnt #(.W(DLY_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_s),
    .load_i     (cnt_load),
    .load_val_i (~dly),
    .en_i       (cnt_en),
    .tc_o       (tc)
  );

  // Next-state logic
  always_comb begin
    mode_d  = mode_q;
    st_d    = st_q;
    start   = 1'b0;
    ld_zero = 1'b0;

    if (halt_r) begin
      mode_d = M_DECEL;
    end else if (go_r && hold_r) begin
      mode_d  = M_HOLD;
      ld_zero = 1'b1;
      start   = (st_q == S_IDLE);
    end else if (hold_r) begin
      mode_d = M_HOLD;
    end else if (go_r) begin
      mode_d = M_ACCEL;
      start  = (st_q == S_IDLE);
    end

    fire      = (st_q == S_RUN) && tc && !step_q;
    last_step = fire && (mode_q == M_DECEL) && at_max;
    dly_dec   = fire && (mode_q == M_ACCEL) && !at_min;
    dly_inc   = fire && (mode_q == M_DECEL) && !at_max;

    if (start)          st_d = S_RUN;
    else if (last_step) st_d = S_IDLE;

    step_d   = fire;
    cnt_load = start || step_q;
    cnt_en   = (st_q == S_RUN) && !tc && !step_q;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q   <= S_IDLE;
      mode_q <= M_ACCEL;
      step_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      step_q <= step_d;
    end
  end

  assign step_o    = step_q;
  assign min_dly_o = at_min;
  assign max_dly_o = at_max;

  p_step_gap_r3: assert property (@(posedge clk) disable iff (!rst_s)
    step_q |=> !step_q);
  p_delay_still_r3: assert property (@(posedge clk) disable iff (!rst_s)
    (!fire && !ld_zero) |=> $stable(dly));
  p_hold_frozen_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (mode_q == M_HOLD && !ld_zero) |=> $stable(dly));
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == S_IDLE && !step_q) |=> !step_q);
  p_halt_first_r10: assert property (@(posedge clk) disable iff (!rst_s)
    halt_r |=> (mode_q == M_DECEL));
endmodule

// File: tb/tb_step_ramp_ctrl.sv
module tb_step_ramp_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go_i = 1'b0, hold_i = 1'b0, halt_i = 1'b0;
  logic step_o, min_dly_o, max_dly_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  step_ramp_ctrl #(.DLY_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .go_i(go_i), .hold_i(hold_i), .halt_i(halt_i),
    .step_o(step_o), .min_dly_o(min_dly_o), .max_dly_o(max_dly_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Count clock edges until a step pulse is seen; -1 if none within limit.
  task automatic wait_step(input int limit, output int n);
    n = -1;
    for (int k = 1; k <= limit; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (step_o) begin
        n = k;
        break;
      end
    end
  endtask

  task automatic do_reset();
    go_i = 0; hold_i = 0; halt_i = 0;
    @(negedge clk);
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(step_o == 0 && max_dly_o == 1 && min_dly_o == 0, "R1 in reset",
        {step_o, max_dly_o, min_dly_o}, 3'b010);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk(step_o == 0, "R1 idle step", step_o, 0);
    chk(max_dly_o == 1, "R1/R11 max flag", max_dly_o, 1);
    chk(min_dly_o == 0, "R1/R11 min flag", min_dly_o, 0);
  endtask

  task automatic t_go_ramp_halt();
    int n;
    int iv [64];
    int cnt;
    do_reset();
    go_i = 1;
    wait_step(40, n);
    chk(n == 19, "R2 first step latency", n, 19);
    for (int d = 14; d >= 0; d--) begin
      wait_step(40, n);
      chk(n == d + 2, "R4 accel interval", n, d + 2);
    end
    chk(min_dly_o == 1 && max_dly_o == 0, "R11 flags at min", min_dly_o, 1);
    for (int k = 0; k < 3; k++) begin
      wait_step(40, n);
      chk(n == 2, "R5 steady at min (R2 go held)", n, 2);
    end
    go_i = 0;
    halt_i = 1;
    cnt = 0;
    for (int k = 0; k < 64; k++) begin
      wait_step(40, n);
      if (n < 0) break;
      iv[cnt] = n;
      cnt++;
    end
    chk(cnt >= 15, "R6 step count in decel", cnt, 15);
    if (cnt >= 15)
      for (int j = 0; j < 15; j++)
        chk(iv[cnt - 15 + j] == 3 + j, "R6 decel interval", iv[cnt - 15 + j], 3 + j);
    chk(max_dly_o == 1 && min_dly_o == 0, "R6/R11 flags at max", max_dly_o, 1);
    wait_step(60, n);
    chk(n == -1, "R6 idle after final step", n, -1);
    halt_i = 0;
  endtask

  task automatic t_hold();
    int n, v1, v2, v3;
    do_reset();
    go_i = 1;
    wait_step(40, n);
    for (int k = 0; k < 3; k++) wait_step(40, n);
    hold_i = 1;
    wait_step(40, n);
    wait_step(40, n);
    wait_step(40, v1);
    wait_step(40, v2);
    wait_step(40, v3);
    chk(v1 == v2 && v2 == v3 && v1 > 2, "R7 hold constant interval", v2, v1);
    go_i = 0; hold_i = 0;
    repeat (3) @(negedge clk);
    go_i = 1;
    wait_step(40, n);
    wait_step(40, n);
    wait_step(40, n);
    chk(n < v1, "R7 run resumes accel", n, v1 - 1);
    go_i = 0;
  endtask

  task automatic t_idle_cmds();
    int n;
    do_reset();
    halt_i = 1;
    wait_step(40, n);
    chk(n == -1, "R8 stop edge keeps idle", n, -1);
    hold_i = 1;
    wait_step(40, n);
    chk(n == -1, "R8 freeze edge keeps idle", n, -1);
    chk(max_dly_o == 1, "R8 delay untouched", max_dly_o, 1);
    halt_i = 0; hold_i = 0;
  endtask

  task automatic t_go_hold();
    int n;
    do_reset();
    go_i = 1; hold_i = 1;
    wait_step(40, n);
    chk(n == 19, "R9 start latency", n, 19);
    chk(min_dly_o == 1, "R9 delay loaded zero", min_dly_o, 1);
    for (int k = 0; k < 3; k++) begin
      wait_step(40, n);
      chk(n == 2, "R9 top rate held", n, 2);
    end
    go_i = 0; hold_i = 0;
  endtask

  task automatic t_priority();
    int n;
    do_reset();
    go_i = 1; halt_i = 1;
    wait_step(50, n);
    chk(n == -1, "R10 stop beats run", n, -1);
    go_i = 0; halt_i = 0;
  endtask

  initial begin
    t_reset();
    t_go_ramp_halt();
    t_hold();
    t_idle_cmds();
    t_go_hold();
    t_priority();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule